// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table out of memory. A client presents a walk request with the virtual address, the byte address of the root table and an access-type flag. The walker splits the address into a top index, a leaf index and a page offset. It fetches the top-level entry, uses the frame in that entry to locate the leaf table, fetches the leaf entry and joins the leaf frame to the offset.

Either entry can be marked not present. The walk then stops at that level and reports a page fault that names the level which failed. Memory is reached through one read port with a request/grant handshake and a read-data strobe that may come after any delay. The walker keeps a single read in flight and a single walk in progress.

Entry format (32 bits): bit 0 is the present flag. Bits 31..12 hold a 20-bit frame number. Bits 11..1 are not interpreted.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `resp_valid` and `mem_req` are 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the cycle after `resp_valid`, so no second walk overlaps the first.
- R3: The first memory read goes to `req_root + 4 * vaddr[31:22]`.
- R4: If the top-level entry has bit 0 clear, the response has `resp_fault` = 1 and `resp_fault_level` = 1, and no second read is issued.
- R5: If the top-level entry is present, the second read goes to `{entry[31:12], 12'h000} + 4 * vaddr[21:12]`.
- R6: If the leaf entry has bit 0 clear, the response has `resp_fault` = 1 and `resp_fault_level` = 2.
- R7: If both entries are present, the response has `resp_fault` = 0, `resp_fault_level` = 0 and `resp_paddr` = `{leaf[31:12], vaddr[11:0]}`.
- R8: `mem_req` and `mem_addr` stay steady until `mem_gnt`. After the grant, `mem_addr` stays steady until `mem_rvalid`. A new read is never requested while one is outstanding.
- R9: `resp_valid` is a one-cycle pulse, and `resp_paddr` is 0 whenever `resp_fault` is 1.
- R10: The request fields are captured when the request is taken, so changes on them during the walk have no effect. `resp_write` returns the captured access type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 32 | Byte address of the top-level table |
| req_write | input | 1 | Access type, 1 for a store |
| mem_req | output | 1 | Memory read request |
| mem_gnt | input | 1 | Memory has taken the read |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Entry read from memory |
| resp_valid | output | 1 | Walk result, one cycle |
| resp_paddr | output | 32 | Physical address, 0 on a fault |
| resp_fault | output | 1 | Page fault |
| resp_fault_level | output | 2 | 1 for the top level, 2 for the leaf, 0 for no fault |
| resp_write | output | 1 | Captured access type |

## Verification
Walks are run against a sparse table image. The image holds present and absent entries at the top level and at the leaf level, so each of the three outcomes (translated, fault at the top, fault at the leaf) shows up both on its own and mixed into a run of random walks. Index values 0 and 1023 and offset 0xFFF show whether the split and the scaling by four are correct at the edges of each field. Grant and data delays from zero to several cycles show whether the port holds its address and keeps a single read in flight. A client that keeps `req_valid` high and changes the request fields during a walk shows whether the fields are captured at the right edge and whether the walker turns away a second request until the first one has answered.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_TOP_REQ,
    WS_TOP_WAIT,
    WS_LEAF_REQ,
    WS_LEAF_WAIT,
    WS_RESP
  } walk_state_t;

  localparam logic [1:0] LVL_NONE = 2'd0;
  localparam logic [1:0] LVL_TOP  = 2'd1;
  localparam logic [1:0] LVL_LEAF = 2'd2;

endpackage

// File: rtl/pt_va_split.sv
module pt_va_split #(
  parameter int L1_W  = 10,
  parameter int L2_W  = 10,
  parameter int OFF_W = 12
) (
  input  logic [L1_W+L2_W+OFF_W-1:0] va_i,
  output logic [L1_W-1:0]            top_idx_o,
  output logic [L2_W-1:0]            leaf_idx_o,
  output logic [OFF_W-1:0]           off_o
);
  localparam int VA_W = L1_W + L2_W + OFF_W;

  assign top_idx_o  = va_i[VA_W-1 -: L1_W];
  assign leaf_idx_o = va_i[OFF_W +: L2_W];
  assign off_o      = va_i[OFF_W-1:0];
endmodule

// File: rtl/pt_slot_addr.sv
module pt_slot_addr #(
  parameter int AW        = 32,
  parameter int IDX_W     = 10,
  parameter int SLOT_LOG2 = 2
) (
  input  logic [AW-1:0]    base_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [AW-1:0]    addr_o
);
  // Byte address of entry idx in a table of 2**SLOT_LOG2-byte entries.
  function automatic logic [AW-1:0] slot_of(input logic [AW-1:0] base,
                                            input logic [IDX_W-1:0] idx);
    logic [AW-1:0] wide;
    wide = {{(AW-IDX_W){1'b0}}, idx};
    return base + (wide << SLOT_LOG2);
  endfunction

  assign addr_o = slot_of(base_i, idx_i);
endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode #(
  parameter int PTE_W = 32,
  parameter int OFF_W = 12
) (
  input  logic [PTE_W-1:0]       pte_i,
  output logic                   present_o,
  output logic [PTE_W-OFF_W-1:0] frame_o,
  output logic [PTE_W-1:0]       frame_base_o
);
  logic unused_attr;

  assign present_o    = pte_i[0];
  assign frame_o      = pte_i[PTE_W-1:OFF_W];
  assign frame_base_o = {pte_i[PTE_W-1:OFF_W], {OFF_W{1'b0}}};
  assign unused_attr  = ^pte_i[OFF_W-1:1];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int L1_W  = 10,
  parameter int L2_W  = 10,
  parameter int OFF_W = 12,
  parameter int PTE_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [L1_W+L2_W+OFF_W-1:0] req_vaddr,
  input  logic [PTE_W-1:0]          req_root,
  input  logic                      req_write,
  output logic                      mem_req,
  input  logic                      mem_gnt,
  output logic [PTE_W-1:0]          mem_addr,
  input  logic                      mem_rvalid,
  input  logic [PTE_W-1:0]          mem_rdata,
  output logic                      resp_valid,
  output logic [PTE_W-1:0]          resp_paddr,
  output logic                      resp_fault,
  output logic [1:0]                resp_fault_level,
  output logic                      resp_write
);
  localparam int VA_W      = L1_W + L2_W + OFF_W;
  localparam int AW        = PTE_W;
  localparam int FRAME_W   = PTE_W - OFF_W;
  localparam int SLOT_LOG2 = $clog2(PTE_W / 8);
  localparam int N_LVL     = 2;

  function automatic logic [AW-1:0] join_paddr(input logic [FRAME_W-1:0] frame,
                                               input logic [OFF_W-1:0] off);
    return {frame, off};
  endfunction

  walk_state_t state_q, state_d;
  logic [VA_W-1:0]   va_q;
  logic [AW-1:0]     root_q;
  logic              wr_q;
  logic [AW-1:0]     leaf_base_q;
  logic [AW-1:0]     paddr_q;
  logic              fault_q;
  logic [1:0]        level_q;

  logic [L1_W-1:0]    top_idx;
  logic [L2_W-1:0]    leaf_idx;
  logic [OFF_W-1:0]   page_off;
  logic               pte_present;
  logic [FRAME_W-1:0] pte_frame;
  logic [AW-1:0]      pte_base;
  logic [AW-1:0]      slot_addr [N_LVL];

  // Named events for the assertions.
  logic walk_accept, top_done, leaf_done, top_fault_ev, leaf_fault_ev, leaf_issue_ev;
  logic in_wait;

  pt_va_split #(.L1_W(L1_W), .L2_W(L2_W), .OFF_W(OFF_W)) u_split (
    .va_i(va_q), .top_idx_o(top_idx), .leaf_idx_o(leaf_idx), .off_o(page_off)
  );

  pt_entry_decode #(.PTE_W(PTE_W), .OFF_W(OFF_W)) u_decode (
    .pte_i(mem_rdata), .present_o(pte_present), .frame_o(pte_frame), .frame_base_o(pte_base)
  );

  genvar g;
  for (g = 0; g < N_LVL; g++) begin : g_lvl
    localparam int IW = (g == 0) ? L1_W : L2_W;
    logic [IW-1:0] idx;
    logic [AW-1:0] base;
    if (g == 0) begin : g_top
      assign idx  = top_idx;
      assign base = root_q;
    end else begin : g_leaf
      assign idx  = leaf_idx;
      assign base = leaf_base_q;
    end
    pt_slot_addr #(.AW(AW), .IDX_W(IW), .SLOT_LOG2(SLOT_LOG2)) u_slot (
      .base_i(base), .idx_i(idx), .addr_o(slot_addr[g])
    );
  end

  assign walk_accept   = req_valid && req_ready;
  assign top_done      = (state_q == WS_TOP_WAIT) && mem_rvalid;
  assign leaf_done     = (state_q == WS_LEAF_WAIT) && mem_rvalid;
  assign top_fault_ev  = top_done && !pte_present;
  assign leaf_fault_ev = leaf_done && !pte_present;
  assign leaf_issue_ev = top_done && pte_present;
  assign in_wait       = (state_q == WS_TOP_WAIT) || (state_q == WS_LEAF_WAIT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WS_IDLE:      if (walk_accept) state_d = WS_TOP_REQ;
      WS_TOP_REQ:   if (mem_gnt) state_d = WS_TOP_WAIT;
      WS_TOP_WAIT:  if (mem_rvalid) state_d = pte_present ? WS_LEAF_REQ : WS_RESP;
      WS_LEAF_REQ:  if (mem_gnt) state_d = WS_LEAF_WAIT;
      WS_LEAF_WAIT: if (mem_rvalid) state_d = WS_RESP;
      WS_RESP:      state_d = WS_IDLE;
      default:      state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= WS_IDLE;
      va_q        <= '0;
      root_q      <= '0;
      wr_q        <= 1'b0;
      leaf_base_q <= '0;
      paddr_q     <= '0;
      fault_q     <= 1'b0;
      level_q     <= LVL_NONE;
    end else begin
      state_q <= state_d;
      if (walk_accept) begin
        va_q   <= req_vaddr;
        root_q <= req_root;
        wr_q   <= req_write;
      end
      if (leaf_issue_ev) leaf_base_q <= pte_base;
      if (top_fault_ev) begin
        paddr_q <= '0;
        fault_q <= 1'b1;
        level_q <= LVL_TOP;
      end else if (leaf_fault_ev) begin
        paddr_q <= '0;
        fault_q <= 1'b1;
        level_q <= LVL_LEAF;
      end else if (leaf_done) begin
        paddr_q <= join_paddr(pte_frame, page_off);
        fault_q <= 1'b0;
        level_q <= LVL_NONE;
      end
    end
  end

  assign req_ready        = (state_q == WS_IDLE);
  assign mem_req          = (state_q == WS_TOP_REQ) || (state_q == WS_LEAF_REQ);
  assign mem_addr         = ((state_q == WS_TOP_REQ) || (state_q == WS_TOP_WAIT)) ? slot_addr[0] :
                            ((state_q == WS_LEAF_REQ) || (state_q == WS_LEAF_WAIT)) ? slot_addr[1] : '0;
  assign resp_valid       = (state_q == WS_RESP);
  assign resp_paddr       = paddr_q;
  assign resp_fault       = fault_q;
  assign resp_fault_level = level_q;
  assign resp_write       = wr_q;

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> req_ready && !mem_req);                                   // R1
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);                                                // R2
  AST_ACCEPT_STARTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    walk_accept |=> mem_req && !req_ready);                                    // R3
  AST_TOP_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    top_fault_ev |=> !mem_req && resp_valid && resp_fault_level == LVL_TOP);   // R4
  AST_LEAF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    leaf_issue_ev |=> mem_req && !resp_valid);                                 // R5
  AST_LEAF_FAULT_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    leaf_fault_ev |=> resp_valid && resp_fault && resp_fault_level == LVL_LEAF); // R6
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));                     // R8
  AST_ADDR_HELD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait && !mem_rvalid |=> !mem_req && $stable(mem_addr));                 // R8
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);                                               // R9
  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault |-> resp_paddr == '0 && resp_fault_level != LVL_NONE); // R9
  AST_OK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_fault |-> resp_fault_level == LVL_NONE);               // R7
  AST_FIELDS_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && !$past(walk_accept) |-> $stable(resp_write));                // R10
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_vaddr, req_root;
  logic        mem_req, mem_gnt, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic        resp_valid, resp_fault, resp_write;
  logic [31:0] resp_paddr;
  logic [1:0]  resp_fault_level;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_root(req_root), .req_write(req_write),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
    .resp_fault_level(resp_fault_level), .resp_write(resp_write)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [31:0] image [logic [31:0]];
  logic [31:0] addr_q [$];
  logic [31:0] exp_paddr_q [$];
  bit          exp_fault_q [$];
  int          exp_lvl_q [$];
  bit          exp_wr_q [$];

  int gnt_delay = 0;
  int rsp_delay = 0;
  int ph = 0;
  int cnt = 0;
  logic [31:0] held = 0;
  bit busy = 0;
  bit run_mon = 0;

  localparam logic [31:0] ROOT = 32'h0001_0000;

  function automatic logic [31:0] peek(input logic [31:0] a);
    if (image.exists(a)) return image[a];
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference: arithmetic written with divisions and masks.
  task automatic predict(input logic [31:0] va, input logic [31:0] root, input bit wr);
    logic [31:0] a1, a2, e1, e2;
    int top, leaf;
    top  = int'(va / 32'd4194304);
    leaf = int'((va / 32'd4096) % 32'd1024);
    a1 = root + 32'(top * 4);
    e1 = peek(a1);
    addr_q.push_back(a1);
    exp_wr_q.push_back(wr);
    if (e1 % 2 == 0) begin
      exp_paddr_q.push_back(32'h0); exp_fault_q.push_back(1'b1); exp_lvl_q.push_back(1);
      return;
    end
    a2 = (e1 & 32'hFFFF_F000) + 32'(leaf * 4);
    addr_q.push_back(a2);
    e2 = peek(a2);
    if (e2 % 2 == 0) begin
      exp_paddr_q.push_back(32'h0); exp_fault_q.push_back(1'b1); exp_lvl_q.push_back(2);
    end else begin
      exp_paddr_q.push_back((e2 & 32'hFFFF_F000) | (va & 32'h0000_0FFF));
      exp_fault_q.push_back(1'b0); exp_lvl_q.push_back(0);
    end
  endtask

  // Every clock: memory responder, port checks, ready model, response compare.
  initial begin
    mem_gnt = 0; mem_rvalid = 0; mem_rdata = 0;
    forever begin
      @(negedge clk);
      #1;
      if (run_mon && rst_n) begin
        chk(req_ready == !busy, "R2 req_ready", {31'b0, req_ready}, {31'b0, !busy});
        if (mem_gnt) begin
          mem_gnt = 0; ph = 1; cnt = 0;
        end else if (mem_rvalid) begin
          mem_rvalid = 0; ph = 0; cnt = 0;
        end else if (ph == 0 && mem_req) begin
          if (addr_q.size() == 0) chk(0, "R4 unexpected read", mem_addr, 32'h0);
          else chk(mem_addr == addr_q[0], "R3/R5 read address", mem_addr, addr_q[0]);
          if (cnt >= gnt_delay) begin
            mem_gnt = 1; held = mem_addr; cnt = 0;
            if (addr_q.size() != 0) void'(addr_q.pop_front());
          end else cnt++;
        end else if (ph == 1) begin
          chk(mem_addr == held && !mem_req, "R8 address held in wait", mem_addr, held);
          if (cnt >= rsp_delay) begin
            mem_rvalid = 1; mem_rdata = peek(held);
          end else cnt++;
        end
        if (resp_valid) begin
          if (exp_fault_q.size() == 0) chk(0, "R9 unexpected response", resp_paddr, 32'h0);
          else begin
            chk(resp_paddr == exp_paddr_q[0], "R7 paddr", resp_paddr, exp_paddr_q[0]);
            chk(resp_fault == exp_fault_q[0], "R4/R6 fault", {31'b0, resp_fault}, {31'b0, exp_fault_q[0]});
            chk(32'(resp_fault_level) == 32'(exp_lvl_q[0]), "R4/R6 fault level",
                32'(resp_fault_level), 32'(exp_lvl_q[0]));
            chk(resp_write == exp_wr_q[0], "R10 access type", {31'b0, resp_write}, {31'b0, exp_wr_q[0]});
            void'(exp_paddr_q.pop_front()); void'(exp_fault_q.pop_front());
            void'(exp_lvl_q.pop_front()); void'(exp_wr_q.pop_front());
          end
        end
        if (req_valid && req_ready) busy = 1;
        if (resp_valid) busy = 0;
      end
    end
  end

  // scramble: keep req_valid high with changing fields until the response.
  task automatic walk(input logic [31:0] va, input bit wr, input bit scramble);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_vaddr = va; req_root = ROOT; req_write = wr;
    predict(va, ROOT, wr);
    @(negedge clk);
    if (!scramble) req_valid = 0;
    while (!resp_valid) begin
      if (scramble) begin
        req_vaddr = $urandom; req_root = $urandom; req_write = ~req_write;
      end
      @(negedge clk);
    end
    req_valid = 0;
    @(negedge clk);
    chk(!resp_valid, "R9 single-cycle response", {31'b0, resp_valid}, 32'h0);
  endtask

  function automatic logic [31:0] mkva(input int t, input int l, input int o);
    return 32'(t) * 32'd4194304 + 32'(l) * 32'd4096 + 32'(o);
  endfunction

  initial begin
    int cyc;
    cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_vaddr = 0; req_root = 0; req_write = 0;
    // Image: top entries k*131 (k=0..7) plus 1023; entry k=3 absent.
    for (int k = 0; k < 8; k++) begin
      logic [31:0] tbl;
      tbl = 32'h0040_0000 + 32'(k) * 32'h1000;
      image[ROOT + 32'(k * 131 * 4)] = tbl | ((k == 3) ? 32'h0 : 32'h1);
      for (int j = 0; j < 16; j++)
        image[tbl + 32'(j * 4)] = (32'h0800_0000 + 32'(k * 64 + j) * 32'h1000) | ((j % 5 == 0) ? 32'h0 : 32'h7);
      image[tbl + 32'(1023 * 4)] = 32'hFFFF_F001;
    end
    image[ROOT + 32'(1023 * 4)] = 32'h0050_0001;
    image[32'h0050_0000 + 32'(1023 * 4)] = 32'hABCD_E001;
    image[32'h0050_0000] = 32'h1234_5001;

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready in reset", {31'b0, req_ready}, 32'h1);
    chk(resp_valid == 1'b0, "R1 no response in reset", {31'b0, resp_valid}, 32'h0);
    chk(mem_req == 1'b0, "R1 no read in reset", {31'b0, mem_req}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !mem_req && !resp_valid, "R1 idle after reset", {29'b0, req_ready, mem_req, resp_valid}, 32'h4);
    run_mon = 1;

    walk(mkva(0, 1, 12'hABC), 0, 0);          // R3 R5 R7 index 0 translation
    walk(mkva(3 * 131, 2, 12'h010), 0, 0);    // R4 top-level fault
    walk(mkva(131, 5, 12'h777), 1, 0);        // R6 leaf fault
    gnt_delay = 3; rsp_delay = 4;
    walk(mkva(1023, 1023, 12'hFFF), 1, 0);    // R8 edges with delays
    walk(mkva(1023, 0, 12'h000), 0, 0);
    walk(mkva(2 * 131, 1023, 12'hFFF), 0, 0);
    gnt_delay = 1; rsp_delay = 0;
    walk(mkva(4 * 131, 7, 12'h123), 1, 1);    // R2 R10 held request, scrambled fields
    walk(mkva(3 * 131, 9, 12'h456), 1, 1);
    walk(mkva(5, 3, 12'h001), 0, 0);          // absent top entry not in image: R4
    for (int n = 0; n < 40; n++) begin
      int k, j;
      k = int'($urandom_range(0, 7));
      j = ($urandom_range(0, 9) == 0) ? 1023 : int'($urandom_range(0, 17));
      gnt_delay = int'($urandom_range(0, 3));
      rsp_delay = int'($urandom_range(0, 3));
      walk(mkva(k * 131, j, int'($urandom_range(0, 4095))), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    repeat (4) @(negedge clk);
    chk(exp_fault_q.size() == 0, "R9 all responses seen", 32'(exp_fault_q.size()), 32'h0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule